// File: doc/BRIEF.md
# Interrupt Arbitration and Stacking Sequencer

This block sits next to a small 8-bit processor core. It decides, at each instruction boundary, whether a hardware interrupt is taken. When the core reports that an instruction has finished, the block qualifies every pending request with its own enable bit and with the global mask bit of the condition code byte. It picks the qualified request with the lowest index and then runs the bus itself, one bus cycle per state. It writes the core context onto the stack, sets the mask bit and reads the 16-bit handler address of the winning source. It then hands the new context back to the core.

The block also runs the return-from-interrupt sequence. It reads the saved context back from the stack. In the same cycle as the last read, it arbitrates again using the restored mask bit. If a qualified request is still pending, it stacks the restored context straight away. The opcode that the core prefetched after the return is never executed. The saved frame holds five bytes and never includes the upper byte of the index register.

Top module: `irq_stack_seq`

## Requirements
- R1: Requests are only sampled in a cycle where `insn_done` is high and the block is idle; while `insn_done` is low, any change on `irq_req`/`irq_en` leaves `busy`, `bus_we` and `bus_re` low.
- R2: At a non-return boundary, a source is taken only if `ccr_in[3]` (the mask bit) is 0 and its `irq_en` bit is 1; if no source qualifies, `resume` is high in that same cycle and `busy` stays low.
- R3: Among qualified sources, the lowest index wins; an unqualified lower index (enable bit 0) does not block a higher index.
- R4: After a taken boundary in cycle n, cycles n+1..n+5 are single write cycles at addresses SP, SP-1, SP-2, SP-3, SP-4 carrying PC[7:0], PC[15:8], X, A and the unmodified CCR; no sixth byte is written.
- R5: Cycles n+6 and n+7 are reads at `VEC_BASE - 2*src` and `VEC_BASE - 2*src + 1` (high byte first, default base 16'hFFFC). In cycle n+8, `ctx_load`, `ctx_svc` and `resume` are high, with `pc_out` equal to {high, low}, `ccr_out` equal to CCR with bit 3 set, `sp_out` = SP-5, and A and X unchanged.
- R6: A boundary with `insn_is_rti` high starts the return, whatever the mask and the requests. Cycles n+1..n+5 are reads at SP+1..SP+5 that restore CCR, A, X, PC[15:8] and PC[7:0].
- R7: In cycle n+5, the block arbitrates again with the restored CCR bit 3. If a source qualifies, cycle n+6 is the first stacking write (at SP+5) and no `ctx_load` happens in between. Otherwise, cycle n+6 has `ctx_load` and `resume` high, `ctx_svc` low, the restored values on the outputs and `sp_out` = SP+5.
- R8: `busy` is high from the cycle after the decision through the `ctx_load` cycle, and low otherwise; no bus cycle happens while `busy` is low.
- R9: During and after reset, `busy`, `bus_we`, `bus_re`, `ctx_load` and `resume` are low, and `ccr_out[3]` is 1.
- R10: The winning source is latched at the decision; request changes during stacking do not change `svc_src` or the handler address read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | N_SRC | Pending request per source, index 0 highest priority |
| irq_en | input | N_SRC | Per-source enable |
| insn_done | input | 1 | Instruction-complete strobe from the core |
| insn_is_rti | input | 1 | The completed instruction is a return-from-interrupt |
| ccr_in | input | DW | Condition code byte at the boundary (bit 3 = mask) |
| a_in | input | DW | Accumulator at the boundary |
| x_in | input | DW | Low index byte at the boundary |
| pc_in | input | AW | Return address at the boundary |
| sp_in | input | AW | Stack pointer at the boundary |
| bus_rdata | input | DW | Read data, valid in the same cycle as `bus_re` |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| busy | output | 1 | Sequencer owns the bus |
| resume | output | 1 | Core may fetch its next opcode |
| ctx_load | output | 1 | Core loads the context outputs |
| ctx_svc | output | 1 | The loaded context enters a handler (0: return) |
| svc_src | output | SRC_W | Latched winning source |
| ccr_out | output | DW | Context CCR |
| a_out | output | DW | Context A |
| x_out | output | DW | Context X |
| pc_out | output | AW | Context PC |
| sp_out | output | AW | Context SP |

## Verification
In the last cycle of a return, the final unstack read and a fresh priority decision fall together. The decision uses a mask bit that was itself read from the stack only four cycles earlier. The bench provokes this three ways: a request held across a return with a clear restored mask, the same with a set restored mask planted in memory, and no pending request. For each case, a behavioural model predicts whether the next cycle is a stacking write at SP+5 or a context load, and it checks every field of every cycle.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  localparam int MASK_BIT = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_PCL,
    ST_PUSH_PCH,
    ST_PUSH_X,
    ST_PUSH_A,
    ST_PUSH_CCR,
    ST_VEC_HI,
    ST_VEC_LO,
    ST_ENTER,
    ST_POP_CCR,
    ST_POP_A,
    ST_POP_X,
    ST_POP_PCH,
    ST_POP_PCL,
    ST_RESUME
  } seq_state_e;

  typedef struct packed {
    logic snap;
    logic sp_dec;
    logic sp_inc;
    logic ld_ccr;
    logic ld_a;
    logic ld_x;
    logic ld_pch;
    logic ld_pcl;
    logic set_mask;
  } ctx_ctl_t;

endpackage

// File: rtl/irq_qual_prio.sv
module irq_qual_prio #(
  parameter int N_SRC = 4,
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] en,
  input  logic             mask,
  output logic             any,
  output logic [SRC_W-1:0] idx
);

  logic [N_SRC-1:0] qual;

  for (genvar g = 0; g < N_SRC; g++) begin : g_qual
    assign qual[g] = req[g] & en[g] & ~mask;
  end

  // Scan downward so the lowest qualified index is the last one written.
  always_comb begin
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (qual[i]) idx = SRC_W'(i);
    end
  end

  assign any = |qual;

endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
  parameter int            N_SRC    = 4,
  parameter int            AW       = 16,
  parameter logic [AW-1:0] VEC_BASE = 16'hFFFC,
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [SRC_W-1:0] src,
  input  logic             lo_sel,
  output logic [AW-1:0]    addr
);

  logic [AW-1:0] slot_off;

  assign slot_off = AW'({src, 1'b0});
  assign addr     = VEC_BASE - slot_off + AW'(lo_sel);

endmodule

// File: rtl/irq_ctx_file.sv
module irq_ctx_file
  import irq_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctx_ctl_t      ctl,
  input  logic [DW-1:0] ccr_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] x_in,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] sp_in,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] ccr_q,
  output logic [DW-1:0] a_q,
  output logic [DW-1:0] x_q,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] sp_q
);

  localparam int PH = AW - DW;

  logic [DW-1:0] ccr_d, a_d, x_d;
  logic [AW-1:0] pc_d, sp_d;
  logic          ccr_en, a_en, x_en, pc_en, sp_en;

  always_comb begin
    ccr_en = ctl.snap | ctl.ld_ccr | ctl.set_mask;
    if (ctl.snap)        ccr_d = ccr_in;
    else if (ctl.ld_ccr) ccr_d = rdata;
    else begin
      ccr_d           = ccr_q;
      ccr_d[MASK_BIT] = 1'b1;
    end

    a_en = ctl.snap | ctl.ld_a;
    a_d  = ctl.snap ? a_in : rdata;

    x_en = ctl.snap | ctl.ld_x;
    x_d  = ctl.snap ? x_in : rdata;

    pc_en = ctl.snap | ctl.ld_pch | ctl.ld_pcl;
    if (ctl.snap)        pc_d = pc_in;
    else if (ctl.ld_pch) pc_d = {rdata[PH-1:0], pc_q[DW-1:0]};
    else                 pc_d = {pc_q[AW-1:DW], rdata};

    sp_en = ctl.snap | ctl.sp_dec | ctl.sp_inc;
    if (ctl.snap)        sp_d = sp_in;
    else if (ctl.sp_dec) sp_d = sp_q - AW'(1);
    else                 sp_d = sp_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_q           <= '0;
      ccr_q[MASK_BIT] <= 1'b1;
      a_q             <= '0;
      x_q             <= '0;
      pc_q            <= '0;
      sp_q            <= '0;
    end else begin
      if (ccr_en) ccr_q <= ccr_d;
      if (a_en)   a_q   <= a_d;
      if (x_en)   x_q   <= x_d;
      if (pc_en)  pc_q  <= pc_d;
      if (sp_en)  sp_q  <= sp_d;
    end
  end

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irq_seq_pkg::*;
#(
  parameter int            N_SRC    = 4,
  parameter int            DW       = 8,
  parameter int            AW       = 16,
  parameter logic [AW-1:0] VEC_BASE = 16'hFFFC,
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] irq_en,
  input  logic             insn_done,
  input  logic             insn_is_rti,
  input  logic [DW-1:0]    ccr_in,
  input  logic [DW-1:0]    a_in,
  input  logic [DW-1:0]    x_in,
  input  logic [AW-1:0]    pc_in,
  input  logic [AW-1:0]    sp_in,
  input  logic [DW-1:0]    bus_rdata,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  output logic             bus_we,
  output logic             bus_re,
  output logic             busy,
  output logic             resume,
  output logic             ctx_load,
  output logic             ctx_svc,
  output logic [SRC_W-1:0] svc_src,
  output logic [DW-1:0]    ccr_out,
  output logic [DW-1:0]    a_out,
  output logic [DW-1:0]    x_out,
  output logic [AW-1:0]    pc_out,
  output logic [AW-1:0]    sp_out
);

  localparam int PH = AW - DW;

  seq_state_e       state_q, state_d;
  logic [SRC_W-1:0] src_q;
  logic [SRC_W-1:0] win_idx;
  logic             win_any;
  logic             mask_sel;
  logic             take;
  logic             src_en;
  ctx_ctl_t         ctl;
  logic [AW-1:0]    vec_addr;
  logic             vec_lo;

  // The return path re-arbitrates with the mask bit just restored from the stack.
  assign mask_sel = (state_q == ST_POP_PCL) ? ccr_out[MASK_BIT] : ccr_in[MASK_BIT];

  irq_qual_prio #(.N_SRC(N_SRC)) u_prio (
    .req  (irq_req),
    .en   (irq_en),
    .mask (mask_sel),
    .any  (win_any),
    .idx  (win_idx)
  );

  assign vec_lo = (state_q == ST_VEC_LO);

  irq_vec_gen #(.N_SRC(N_SRC), .AW(AW), .VEC_BASE(VEC_BASE)) u_vec (
    .src    (src_q),
    .lo_sel (vec_lo),
    .addr   (vec_addr)
  );

  irq_ctx_file #(.DW(DW), .AW(AW)) u_ctx (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .ccr_in (ccr_in),
    .a_in   (a_in),
    .x_in   (x_in),
    .pc_in  (pc_in),
    .sp_in  (sp_in),
    .rdata  (bus_rdata),
    .ccr_q  (ccr_out),
    .a_q    (a_out),
    .x_q    (x_out),
    .pc_q   (pc_out),
    .sp_q   (sp_out)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    take    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (insn_done) begin
          if (insn_is_rti) begin
            state_d = ST_POP_CCR;
          end else if (win_any) begin
            state_d = ST_PUSH_PCL;
            take    = 1'b1;
          end
        end
      end
      ST_PUSH_PCL: state_d = ST_PUSH_PCH;
      ST_PUSH_PCH: state_d = ST_PUSH_X;
      ST_PUSH_X:   state_d = ST_PUSH_A;
      ST_PUSH_A:   state_d = ST_PUSH_CCR;
      ST_PUSH_CCR: state_d = ST_VEC_HI;
      ST_VEC_HI:   state_d = ST_VEC_LO;
      ST_VEC_LO:   state_d = ST_ENTER;
      ST_ENTER:    state_d = ST_IDLE;
      ST_POP_CCR:  state_d = ST_POP_A;
      ST_POP_A:    state_d = ST_POP_X;
      ST_POP_X:    state_d = ST_POP_PCH;
      ST_POP_PCH:  state_d = ST_POP_PCL;
      ST_POP_PCL: begin
        if (win_any) begin
          state_d = ST_PUSH_PCL;
          take    = 1'b1;
        end else begin
          state_d = ST_RESUME;
        end
      end
      ST_RESUME:   state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // Context register controls
  always_comb begin
    ctl          = '0;
    ctl.snap     = (state_q == ST_IDLE) & insn_done & (insn_is_rti | win_any);
    ctl.sp_dec   = (state_q == ST_PUSH_PCL) | (state_q == ST_PUSH_PCH) |
                   (state_q == ST_PUSH_X)   | (state_q == ST_PUSH_A)   |
                   (state_q == ST_PUSH_CCR);
    ctl.sp_inc   = (state_q == ST_POP_CCR) | (state_q == ST_POP_A) |
                   (state_q == ST_POP_X)   | (state_q == ST_POP_PCH) |
                   (state_q == ST_POP_PCL);
    ctl.ld_ccr   = (state_q == ST_POP_CCR);
    ctl.ld_a     = (state_q == ST_POP_A);
    ctl.ld_x     = (state_q == ST_POP_X);
    ctl.ld_pch   = (state_q == ST_POP_PCH) | (state_q == ST_VEC_HI);
    ctl.ld_pcl   = (state_q == ST_POP_PCL) | (state_q == ST_VEC_LO);
    ctl.set_mask = (state_q == ST_VEC_HI);
  end

  // Bus drive
  always_comb begin
    bus_addr  = '0;
    bus_wdata = '0;
    bus_we    = 1'b0;
    bus_re    = 1'b0;
    unique case (state_q)
      ST_PUSH_PCL: begin bus_we = 1'b1; bus_addr = sp_out; bus_wdata = pc_out[DW-1:0]; end
      ST_PUSH_PCH: begin bus_we = 1'b1; bus_addr = sp_out; bus_wdata = DW'(pc_out[AW-1:AW-PH]); end
      ST_PUSH_X:   begin bus_we = 1'b1; bus_addr = sp_out; bus_wdata = x_out; end
      ST_PUSH_A:   begin bus_we = 1'b1; bus_addr = sp_out; bus_wdata = a_out; end
      ST_PUSH_CCR: begin bus_we = 1'b1; bus_addr = sp_out; bus_wdata = ccr_out; end
      ST_VEC_HI,
      ST_VEC_LO:   begin bus_re = 1'b1; bus_addr = vec_addr; end
      ST_POP_CCR,
      ST_POP_A,
      ST_POP_X,
      ST_POP_PCH,
      ST_POP_PCL:  begin bus_re = 1'b1; bus_addr = sp_out + AW'(1); end
      default:     begin bus_we = 1'b0; end
    endcase
  end

  assign busy     = (state_q != ST_IDLE);
  assign ctx_load = (state_q == ST_ENTER) | (state_q == ST_RESUME);
  assign ctx_svc  = (state_q == ST_ENTER);
  assign resume   = ctx_load |
                    ((state_q == ST_IDLE) & insn_done & ~insn_is_rti & ~win_any);
  assign src_en   = take;
  assign svc_src  = src_q;

  // State and winner registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
    end else begin
      state_q <= state_d;
      if (src_en) src_q <= win_idx;
    end
  end

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk
  import irq_seq_pkg::*;
#(
  parameter int SRC_W = 2,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             insn_done,
  input logic             busy,
  input logic             bus_we,
  input logic             bus_re,
  input logic             ctx_load,
  input logic             ctx_svc,
  input logic             resume,
  input logic [SRC_W-1:0] svc_src,
  input logic [DW-1:0]    ccr_out
);

  AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re)); // R4

  AST_START_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(insn_done)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_we && !bus_re)); // R8

  AST_MASK_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_load && ctx_svc) |-> ccr_out[MASK_BIT]); // R5

  AST_LOAD_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load |=> !busy); // R8

  AST_NO_TAKE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (resume && !ctx_load) |=> !busy); // R2

  AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && $past(bus_we)) |-> $stable(svc_src)); // R10

endmodule

bind irq_stack_seq irq_seq_chk #(.SRC_W(SRC_W), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .insn_done (insn_done),
  .busy      (busy),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .ctx_load  (ctx_load),
  .ctx_svc   (ctx_svc),
  .resume    (resume),
  .svc_src   (svc_src),
  .ccr_out   (ccr_out)
);

// File: tb/tb_irq_stack_seq.sv
module tb_irq_stack_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic [3:0]  irq_req, irq_en;
  logic        insn_done, insn_is_rti;
  logic [7:0]  ccr_in, a_in, x_in;
  logic [15:0] pc_in, sp_in;
  logic [7:0]  bus_rdata;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we, bus_re, busy, resume, ctx_load, ctx_svc;
  logic [1:0]  svc_src;
  logic [7:0]  ccr_out, a_out, x_out;
  logic [15:0] pc_out, sp_out;

  irq_stack_seq dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .insn_done(insn_done), .insn_is_rti(insn_is_rti),
    .ccr_in(ccr_in), .a_in(a_in), .x_in(x_in), .pc_in(pc_in), .sp_in(sp_in),
    .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .busy(busy), .resume(resume),
    .ctx_load(ctx_load), .ctx_svc(ctx_svc), .svc_src(svc_src),
    .ccr_out(ccr_out), .a_out(a_out), .x_out(x_out), .pc_out(pc_out), .sp_out(sp_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Bus memory seen by the design, and the model's own copy.
  logic [7:0] mem     [256];
  logic [7:0] ref_mem [256];
  assign bus_rdata = mem[bus_addr[7:0]];
  always @(posedge clk) if (bus_we) mem[bus_addr[7:0]] <= bus_wdata;

  typedef struct {
    bit          busy, we, re, ld, svc, res, chk_src;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [1:0]  src;
    logic [15:0] pc, sp;
    logic [7:0]  ccr, a, x;
    string       tag;
  } exp_t;

  exp_t  expq[$];
  int    n_tests, n_fail, cyc;
  bit    run_cmp, done_flag;
  string idle_tag;

  function automatic exp_t blank(string tag);
    exp_t r;
    r.busy = 0; r.we = 0; r.re = 0; r.ld = 0; r.svc = 0; r.res = 0; r.chk_src = 0;
    r.addr = '0; r.wd = '0; r.src = '0; r.pc = '0; r.sp = '0;
    r.ccr = '0; r.a = '0; r.x = '0; r.tag = tag;
    return r;
  endfunction

  function automatic int pick(logic [3:0] r, logic [3:0] e);
    for (int i = 0; i < 4; i++) if (r[i] && e[i]) return i;
    return -1;
  endfunction

  function automatic void model_entry(logic [15:0] pc, logic [7:0] a, logic [7:0] x,
                                      logic [7:0] ccr, logic [15:0] sp, int w, string tag);
    logic [7:0]  bytes [5];
    logic [15:0] vh;
    exp_t        r;
    bytes[0] = pc[7:0]; bytes[1] = pc[15:8]; bytes[2] = x; bytes[3] = a; bytes[4] = ccr;
    for (int k = 0; k < 5; k++) begin
      r = blank(tag); r.busy = 1; r.we = 1; r.addr = sp - 16'(k); r.wd = bytes[k];
      r.chk_src = 1; r.src = 2'(w);
      ref_mem[r.addr[7:0]] = bytes[k];
      expq.push_back(r);
    end
    vh = 16'hFFFC - 16'(2 * w);
    r = blank(tag); r.busy = 1; r.re = 1; r.addr = vh; r.chk_src = 1; r.src = 2'(w);
    expq.push_back(r);
    r.addr = vh + 16'd1;
    expq.push_back(r);
    r = blank(tag); r.busy = 1; r.ld = 1; r.svc = 1; r.res = 1; r.chk_src = 1; r.src = 2'(w);
    r.pc = {ref_mem[vh[7:0]], ref_mem[8'(vh[7:0] + 8'd1)]};
    r.ccr = ccr | 8'h08; r.a = a; r.x = x; r.sp = sp - 16'd5;
    expq.push_back(r);
  endfunction

  function automatic void model_rti(logic [15:0] sp, string tag);
    exp_t        r;
    logic [7:0]  c, a, x;
    logic [15:0] pc, nsp;
    int          w;
    for (int k = 1; k <= 5; k++) begin
      r = blank(tag); r.busy = 1; r.re = 1; r.addr = sp + 16'(k);
      expq.push_back(r);
    end
    c  = ref_mem[8'(sp[7:0] + 8'd1)];
    a  = ref_mem[8'(sp[7:0] + 8'd2)];
    x  = ref_mem[8'(sp[7:0] + 8'd3)];
    pc = {ref_mem[8'(sp[7:0] + 8'd4)], ref_mem[8'(sp[7:0] + 8'd5)]};
    nsp = sp + 16'd5;
    w = c[3] ? -1 : pick(irq_req, irq_en);
    if (w >= 0) begin
      model_entry(pc, a, x, c, nsp, w, tag);
    end else begin
      r = blank(tag); r.busy = 1; r.ld = 1; r.res = 1;
      r.pc = pc; r.ccr = c; r.a = a; r.x = x; r.sp = nsp;
      expq.push_back(r);
    end
  endfunction

  // Compare every cycle, away from the rising edge.
  always @(negedge clk) begin
    exp_t e;
    bit   ok;
    #1;
    if (run_cmp && !done_flag) begin
      if (expq.size() > 0) e = expq.pop_front();
      else e = blank(idle_tag);
      ok = (busy == e.busy) && (bus_we == e.we) && (bus_re == e.re) &&
           (ctx_load == e.ld) && (resume == e.res);
      if (e.we || e.re) ok = ok && (bus_addr == e.addr);
      if (e.we) ok = ok && (bus_wdata == e.wd);
      if (e.ld) ok = ok && (ctx_svc == e.svc) && (pc_out == e.pc) && (ccr_out == e.ccr) &&
                     (a_out == e.a) && (x_out == e.x) && (sp_out == e.sp);
      if (e.chk_src) ok = ok && (svc_src == e.src);
      n_tests++;
      if (!ok) begin
        n_fail++;
        $display("FAIL %s t=%0t busy=%b/%b we=%b/%b re=%b/%b addr=%h/%h wd=%h/%h ld=%b/%b svc=%b/%b res=%b/%b pc=%h/%h ccr=%h/%h a=%h/%h x=%h/%h sp=%h/%h src=%0d/%0d",
                 e.tag, $time, busy, e.busy, bus_we, e.we, bus_re, e.re, bus_addr, e.addr,
                 bus_wdata, e.wd, ctx_load, e.ld, ctx_svc, e.svc, resume, e.res, pc_out, e.pc,
                 ccr_out, e.ccr, a_out, e.a, x_out, e.x, sp_out, e.sp, svc_src, e.src);
      end
    end
  end

  task automatic boundary(input bit rti, input logic [7:0] ccr, input logic [7:0] a,
                          input logic [7:0] x, input logic [15:0] pc, input logic [15:0] sp,
                          input int chg_at, input logic [3:0] chg_req, input string tag);
    exp_t r;
    int   w;
    @(negedge clk);
    insn_done = 1; insn_is_rti = rti;
    ccr_in = ccr; a_in = a; x_in = x; pc_in = pc; sp_in = sp;
    r = blank(tag);
    if (rti) begin
      expq.push_back(r);
      model_rti(sp, tag);
    end else begin
      w = ccr[3] ? -1 : pick(irq_req, irq_en);
      r.res = (w < 0);
      expq.push_back(r);
      if (w >= 0) model_entry(pc, a, x, ccr, sp, w, tag);
    end
    for (int c = 1; c < 100; c++) begin
      @(negedge clk);
      if (c == 1) begin insn_done = 0; insn_is_rti = 0; end
      if (c == chg_at) irq_req = chg_req;
      if (expq.size() == 0) break;
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired at cycle %0d, expected completion before %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    n_tests = 0; n_fail = 0; cyc = 0; run_cmp = 0; done_flag = 0; idle_tag = "R9";
    rst_n = 0; irq_req = 0; irq_en = 0; insn_done = 0; insn_is_rti = 0;
    ccr_in = 0; a_in = 0; x_in = 0; pc_in = 0; sp_in = 0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i ^ 8'h5A); ref_mem[i] = 8'(i ^ 8'h5A);
    end
    for (int i = 0; i < 4; i++) begin
      mem[8'hFC - 2 * i] = 8'hC0 + 8'(i); ref_mem[8'hFC - 2 * i] = 8'hC0 + 8'(i);
      mem[8'hFD - 2 * i] = 8'h10 * 8'(i + 1); ref_mem[8'hFD - 2 * i] = 8'h10 * 8'(i + 1);
    end
    repeat (3) @(negedge clk);
    run_cmp = 1;
    @(negedge clk);
    // R9: reset state of the mask bit
    n_tests++;
    if (ccr_out[3] !== 1'b1 || busy !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 reset ccr_out[3]=%b busy=%b, expected 1 and 0", ccr_out[3], busy);
    end
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1: requests toggle with no boundary
    idle_tag = "R1";
    irq_req = 4'b1111; irq_en = 4'b1111;
    repeat (3) @(negedge clk);
    irq_req = 4'b0101;
    repeat (3) @(negedge clk);
    idle_tag = "R8";

    // R2: masked, then disabled
    irq_req = 4'b0100; irq_en = 4'b1111;
    boundary(0, 8'h08, 8'h11, 8'h22, 16'h1000, 16'h0060, 0, 4'b0, "R2");
    irq_en = 4'b1011;
    boundary(0, 8'h00, 8'h11, 8'h22, 16'h1002, 16'h0060, 0, 4'b0, "R2");

    // R4/R5: single source 2
    irq_en = 4'b1111;
    boundary(0, 8'h01, 8'hA5, 8'h5A, 16'h1234, 16'h0060, 0, 4'b0, "R4/R5");

    // R3: simultaneous 1 and 3, then a disabled lower index
    irq_req = 4'b1010;
    boundary(0, 8'h00, 8'h33, 8'h44, 16'h2345, 16'h0060, 0, 4'b0, "R3");
    irq_req = 4'b0011; irq_en = 4'b1110;
    boundary(0, 8'h04, 8'h55, 8'h66, 16'h3456, 16'h0070, 0, 4'b0, "R3");

    // R10: source 0 appears during stacking for source 3
    irq_req = 4'b1000; irq_en = 4'b1111;
    boundary(0, 8'h00, 8'h77, 8'h88, 16'h4567, 16'h0060, 2, 4'b1001, "R10");

    // R6/R7: return with nothing pending (frame from the R10 entry)
    irq_req = 4'b0000;
    boundary(1, 8'h08, 8'h00, 8'h00, 16'h9999, 16'h005B, 0, 4'b0, "R6/R7");

    // R7: return with a request pending and a clear restored mask
    irq_req = 4'b0001;
    boundary(0, 8'h02, 8'h12, 8'h34, 16'h5678, 16'h0060, 0, 4'b0, "R4/R5");
    irq_req = 4'b0100;
    boundary(1, 8'h08, 8'h00, 8'h00, 16'h9999, 16'h005B, 0, 4'b0, "R7");

    // R7: request pending but restored mask set
    mem[8'h41] = 8'h0C; ref_mem[8'h41] = 8'h0C;
    mem[8'h42] = 8'h9A; ref_mem[8'h42] = 8'h9A;
    mem[8'h43] = 8'hBC; ref_mem[8'h43] = 8'hBC;
    mem[8'h44] = 8'h6E; ref_mem[8'h44] = 8'h6E;
    mem[8'h45] = 8'h0F; ref_mem[8'h45] = 8'h0F;
    boundary(1, 8'h00, 8'h00, 8'h00, 16'h9999, 16'h0040, 0, 4'b0, "R6/R7");

    irq_req = 4'b0000;
    repeat (4) @(negedge clk);
    #2;
    finish_run();
  end

endmodule